// File: doc/BRIEF.md
# Privileged Status Flags Register

This block holds the 32-bit status and control flags word of a processor core and decides, bit by bit, which write is allowed to change it. Four sources can write it: a full-word or half-word load from a pop-style instruction, an interrupt-return load, a task-switch load, and a six-flag update from the arithmetic unit. A single-step event also clears the trap bit. Which bits a write may change depends on the write source, the current privilege level, the I/O privilege level held in the register, and an external enable for the identification bit. Reserved positions are forced to fixed values after every update.

The core drives at most one event of each kind per clock. Every change shows at the outputs one clock after the edge that samples it. The whole word, its low 16 bits as a separate view for legacy-width accesses, and each control bit are available as outputs.

Top module: `priv_flags_reg`

## Requirements
- R1: After reset the register reads 0x00000002.
- R2: Bits 31:22, 20:19, 15, 5 and 3 always read 0, and bit 1 always reads 1, whatever is written.
- R3: The identification bit (bit 21) changes on a pop, interrupt-return or task-switch write only while `id_enable_i` is 1. Otherwise it keeps its value.
- R4: A pop or interrupt-return write changes the interrupt-enable bit (bit 9) only when `cpl_i` is numerically at or below the current I/O privilege level (bits 13:12). Otherwise bit 9 keeps its value.
- R5: A pop or interrupt-return write changes the I/O privilege level field (bits 13:12) only when `cpl_i` is 0.
- R6: A pop write never changes the virtual-mode bit (bit 17).
- R7: An interrupt-return write loads bit 17 from its data only when `cpl_i` is 0. At other levels bit 17 keeps its value.
- R8: A task-switch write loads bit 17, bits 13:12, bit 9 and every other non-reserved bit from its data at any privilege level. Bit 21 is still subject to R3.
- R9: A pop write with `pop_half_i` = 1 leaves bits 31:16 unchanged. It applies the rules above to bits 15:0 only.
- R10: An arithmetic update loads `alu_flags_i[5:0]` into bits 11, 7, 6, 4, 2 and 0 (OF, SF, ZF, AF, PF, CF, in that order from bit 5 down). It leaves every other bit alone, and for those six bits it overrides a write from another source in the same cycle.
- R11: `step_taken_i` clears the trap bit (bit 8) at the next edge, overriding any write of that bit in the same cycle.
- R12: When several full-word sources are active in one cycle, only one is applied: task switch first, then interrupt return, then pop.
- R13: `flags_lo_o` equals bits 15:0 of `flags_o`. The control outputs mirror fixed positions: ID 21, VM 17, RF 16, AC 18, NT 14, IOPL 13:12, DF 10, IF 9, TF 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpl_i | input | 2 | Current privilege level |
| id_enable_i | input | 1 | Allows the identification bit to change |
| pop_we_i | input | 1 | Pop-style write strobe |
| pop_half_i | input | 1 | Pop write is 16 bits wide |
| pop_data_i | input | 32 | Pop write data |
| iret_we_i | input | 1 | Interrupt-return write strobe |
| iret_data_i | input | 32 | Interrupt-return write data |
| task_we_i | input | 1 | Task-switch write strobe |
| task_data_i | input | 32 | Task-switch write data |
| alu_we_i | input | 1 | Arithmetic flag update strobe |
| alu_flags_i | input | 6 | {OF, SF, ZF, AF, PF, CF} |
| step_taken_i | input | 1 | Single-step interrupt taken |
| flags_o | output | 32 | Whole register |
| flags_lo_o | output | 16 | Low 16-bit view |
| id_o | output | 1 | Identification bit |
| vm_o | output | 1 | Virtual-mode bit |
| rf_o | output | 1 | Resume bit |
| ac_o | output | 1 | Alignment-check bit |
| nt_o | output | 1 | Nested-task bit |
| iopl_o | output | 2 | I/O privilege level |
| df_o | output | 1 | Direction bit |
| if_o | output | 1 | Interrupt-enable bit |
| tf_o | output | 1 | Trap bit |

## Verification
The properties assume that the inputs are at known levels while reset is low and that `cpl_i` is stable during the cycle that samples a write. They read the I/O privilege level from the register, not from the data being written. The stimulus changes inputs only on the falling edge and returns every strobe to 0 after each operation. It builds collisions on purpose, with pop plus task switch, pop plus arithmetic update, and pop plus single step in one cycle. This lets the priority and override rules be observed without ever leaving a strobe at an unknown value.

// File: rtl/psfr_pkg.sv
package psfr_pkg;
    localparam int FW = 32;
    localparam int HW = FW / 2;
    localparam int ALU_N = 6;

    localparam int B_CF   = 0;
    localparam int B_ONE  = 1;
    localparam int B_PF   = 2;
    localparam int B_AF   = 4;
    localparam int B_ZF   = 6;
    localparam int B_SF   = 7;
    localparam int B_TF   = 8;
    localparam int B_IF   = 9;
    localparam int B_DF   = 10;
    localparam int B_OF   = 11;
    localparam int B_IOPL = 12;
    localparam int B_NT   = 14;
    localparam int B_RF   = 16;
    localparam int B_VM   = 17;
    localparam int B_AC   = 18;
    localparam int B_ID   = 21;

    localparam logic [FW-1:0] FIXED_ONE  = 32'h0000_0002;
    localparam logic [FW-1:0] FIXED_ZERO = 32'hFFD8_8028;
    localparam logic [FW-1:0] WRITABLE   = ~(FIXED_ONE | FIXED_ZERO);
    localparam logic [FW-1:0] RESET_VAL  = FIXED_ONE;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_POP  = 2'd1,
        SRC_IRET = 2'd2,
        SRC_TASK = 2'd3
    } wsrc_e;

    typedef struct packed {
        logic [FW-1:0] word;
    } flags_state_t;

    function automatic int alu_pos(input int k);
        case (k)
            5:       return B_OF;
            4:       return B_SF;
            3:       return B_ZF;
            2:       return B_AF;
            1:       return B_PF;
            default: return B_CF;
        endcase
    endfunction
endpackage

// File: rtl/psfr_src_sel.sv
module psfr_src_sel
    import psfr_pkg::*;
(
    input  logic          pop_we,
    input  logic [FW-1:0] pop_data,
    input  logic          iret_we,
    input  logic [FW-1:0] iret_data,
    input  logic          task_we,
    input  logic [FW-1:0] task_data,
    output wsrc_e         src,
    output logic [FW-1:0] data
);
    always_comb begin
        src  = SRC_NONE;
        data = '0;
        if (task_we) begin
            src  = SRC_TASK;
            data = task_data;
        end else if (iret_we) begin
            src  = SRC_IRET;
            data = iret_data;
        end else if (pop_we) begin
            src  = SRC_POP;
            data = pop_data;
        end
    end

    always_comb begin
        if (task_we) begin
            AST_TASK_FIRST: assert (src == SRC_TASK); // R12
        end
    end
endmodule

// File: rtl/psfr_wmask.sv
module psfr_wmask
    import psfr_pkg::*;
(
    input  wsrc_e         src,
    input  logic          half,
    input  logic [1:0]    cpl,
    input  logic [1:0]    iopl,
    input  logic          id_en,
    output logic [FW-1:0] mask
);
    logic guarded;
    logic cpl_zero;
    logic if_ok;
    logic vm_ok;
    logic hi_ok;

    always_comb begin
        guarded  = (src == SRC_POP) || (src == SRC_IRET);
        cpl_zero = (cpl == 2'd0);
        if_ok    = !guarded || (cpl <= iopl);
        vm_ok    = (src == SRC_TASK) || ((src == SRC_IRET) && cpl_zero);
        hi_ok    = !((src == SRC_POP) && half);
    end

    for (genvar b = 0; b < FW; b++) begin : g_bit
        if (!WRITABLE[b]) begin : g_fixed
            assign mask[b] = 1'b0;
        end else if (b == B_ID) begin : g_id
            assign mask[b] = (src != SRC_NONE) && id_en && hi_ok;
        end else if (b == B_VM) begin : g_vm
            assign mask[b] = vm_ok;
        end else if (b == B_IOPL || b == B_IOPL + 1) begin : g_iopl
            assign mask[b] = (src != SRC_NONE) && (!guarded || cpl_zero);
        end else if (b == B_IF) begin : g_if
            assign mask[b] = (src != SRC_NONE) && if_ok;
        end else if (b >= HW) begin : g_hi
            assign mask[b] = (src != SRC_NONE) && hi_ok;
        end else begin : g_lo
            assign mask[b] = (src != SRC_NONE);
        end
    end

    always_comb begin
        if (src == SRC_POP) begin
            AST_POP_NO_VM: assert (!mask[B_VM]); // R6
        end
    end
endmodule

// File: rtl/psfr_alu_merge.sv
module psfr_alu_merge
    import psfr_pkg::*;
(
    input  logic [FW-1:0]    word_in,
    input  logic             alu_we,
    input  logic [ALU_N-1:0] alu_flags,
    output logic [FW-1:0]    word_out
);
    logic [FW-1:0] arith_mask;
    logic [FW-1:0] arith_val;

    always_comb begin
        arith_mask = '0;
        arith_val  = '0;
        for (int k = 0; k < ALU_N; k++) begin
            arith_mask[alu_pos(k)] = 1'b1;
            arith_val[alu_pos(k)]  = alu_flags[k];
        end
        word_out = alu_we ? ((word_in & ~arith_mask) | arith_val) : word_in;
    end
endmodule

// File: rtl/priv_flags_reg.sv
module priv_flags_reg
    import psfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cpl_i,
    input  logic              id_enable_i,
    input  logic              pop_we_i,
    input  logic              pop_half_i,
    input  logic [FW-1:0]     pop_data_i,
    input  logic              iret_we_i,
    input  logic [FW-1:0]     iret_data_i,
    input  logic              task_we_i,
    input  logic [FW-1:0]     task_data_i,
    input  logic              alu_we_i,
    input  logic [ALU_N-1:0]  alu_flags_i,
    input  logic              step_taken_i,
    output logic [FW-1:0]     flags_o,
    output logic [HW-1:0]     flags_lo_o,
    output logic              id_o,
    output logic              vm_o,
    output logic              rf_o,
    output logic              ac_o,
    output logic              nt_o,
    output logic [1:0]        iopl_o,
    output logic              df_o,
    output logic              if_o,
    output logic              tf_o
);
    flags_state_t  st_d, st_q;
    wsrc_e         src;
    logic [FW-1:0] wdata;
    logic [FW-1:0] wmask;
    logic [FW-1:0] merged;
    logic [FW-1:0] after_alu;

    psfr_src_sel u_sel (
        .pop_we    (pop_we_i),
        .pop_data  (pop_data_i),
        .iret_we   (iret_we_i),
        .iret_data (iret_data_i),
        .task_we   (task_we_i),
        .task_data (task_data_i),
        .src       (src),
        .data      (wdata)
    );

    psfr_wmask u_mask (
        .src   (src),
        .half  (pop_half_i),
        .cpl   (cpl_i),
        .iopl  (st_q.word[B_IOPL +: 2]),
        .id_en (id_enable_i),
        .mask  (wmask)
    );

    assign merged = (st_q.word & ~wmask) | (wdata & wmask);

    psfr_alu_merge u_alu (
        .word_in   (merged),
        .alu_we    (alu_we_i),
        .alu_flags (alu_flags_i),
        .word_out  (after_alu)
    );

    always_comb begin
        st_d.word = after_alu;
        if (step_taken_i) begin
            st_d.word[B_TF] = 1'b0;
        end
        st_d.word = (st_d.word & ~FIXED_ZERO) | FIXED_ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.word <= RESET_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o    = st_q.word;
    assign flags_lo_o = st_q.word[HW-1:0];
    assign id_o       = st_q.word[B_ID];
    assign vm_o       = st_q.word[B_VM];
    assign rf_o       = st_q.word[B_RF];
    assign ac_o       = st_q.word[B_AC];
    assign nt_o       = st_q.word[B_NT];
    assign iopl_o     = st_q.word[B_IOPL +: 2];
    assign df_o       = st_q.word[B_DF];
    assign if_o       = st_q.word[B_IF];
    assign tf_o       = st_q.word[B_TF];

    logic pop_only;
    assign pop_only = pop_we_i && !iret_we_i && !task_we_i;

    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[B_ONE] && ((flags_o & FIXED_ZERO) == '0)); // R2

    AST_ID_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !id_enable_i |=> id_o == $past(id_o)); // R3

    AST_IF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        pop_only && (cpl_i > iopl_o) |=> if_o == $past(if_o)); // R4

    AST_IOPL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        pop_only && (cpl_i != 2'd0) |=> iopl_o == $past(iopl_o)); // R5

    AST_POP_VM_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        pop_only |=> vm_o == $past(vm_o)); // R6

    AST_IRET_VM_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        iret_we_i && !task_we_i && (cpl_i != 2'd0) |=> vm_o == $past(vm_o)); // R7

    AST_STEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        step_taken_i |=> !tf_o); // R11

    AST_HALF_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        pop_only && pop_half_i |=> flags_o[FW-1:HW] == $past(flags_o[FW-1:HW])); // R9
endmodule

// File: tb/sim_priv_flags_reg.sv
`timescale 1ns/100ps
module sim_priv_flags_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cpl = 2'd0;
    logic        id_en = 1'b0;
    logic        pop_we = 1'b0, pop_half = 1'b0, iret_we = 1'b0, task_we = 1'b0;
    logic        alu_we = 1'b0, step = 1'b0;
    logic [31:0] pop_d = '0, iret_d = '0, task_d = '0;
    logic [5:0]  aluf = '0;
    logic [31:0] flags;
    logic [15:0] flags_lo;
    logic        id_b, vm_b, rf_b, ac_b, nt_b, df_b, if_b, tf_b;
    logic [1:0]  iopl_b;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [31:0] word;
        string       tag;
    } exp_t;
    exp_t sbq[$];
    logic [31:0] model_q;

    always #2.5 clk = ~clk;

    priv_flags_reg u0 (
        .clk(clk), .rst_n(rst_n), .cpl_i(cpl), .id_enable_i(id_en),
        .pop_we_i(pop_we), .pop_half_i(pop_half), .pop_data_i(pop_d),
        .iret_we_i(iret_we), .iret_data_i(iret_d),
        .task_we_i(task_we), .task_data_i(task_d),
        .alu_we_i(alu_we), .alu_flags_i(aluf), .step_taken_i(step),
        .flags_o(flags), .flags_lo_o(flags_lo), .id_o(id_b), .vm_o(vm_b),
        .rf_o(rf_b), .ac_o(ac_b), .nt_o(nt_b), .iopl_o(iopl_b),
        .df_o(df_b), .if_o(if_b), .tf_o(tf_b)
    );

    function automatic logic [31:0] model(input logic [31:0] cur);
        logic [31:0] n;
        n = cur;
        if (task_we) begin
            n = task_d;
            if (!id_en) n[21] = cur[21];                         // R3, R8
        end else if (iret_we || pop_we) begin
            n = iret_we ? iret_d : pop_d;
            if (!id_en) n[21] = cur[21];                         // R3
            if (cpl != 2'd0) n[13:12] = cur[13:12];              // R5
            if (cpl > cur[13:12]) n[9] = cur[9];                 // R4
            if (!iret_we || cpl != 2'd0) n[17] = cur[17];        // R6, R7
            if (!iret_we && pop_half) n[31:16] = cur[31:16];     // R9
        end
        if (alu_we) begin                                        // R10
            n[11] = aluf[5]; n[7] = aluf[4]; n[6] = aluf[3];
            n[4]  = aluf[2]; n[2] = aluf[1]; n[0] = aluf[0];
        end
        if (step) n[8] = 1'b0;                                   // R11
        return (n & 32'h0027_7FD5) | 32'h0000_0002;              // R2
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares one expected item per sampled edge
    always @(posedge clk) begin
        #1;
        if (sbq.size() > 0) begin
            exp_t e;
            logic [31:0] ctl;
            e = sbq.pop_front();
            check(e.tag, flags, e.word);
            check("R13 lo view", {16'h0, flags_lo}, {16'h0, e.word[15:0]});
            ctl = {21'h0, id_b, vm_b, rf_b, ac_b, nt_b, iopl_b, df_b, if_b, tf_b};
            check("R13 ctl bits", ctl,
                  {21'h0, e.word[21], e.word[17], e.word[16], e.word[18], e.word[14],
                   e.word[13:12], e.word[10], e.word[9], e.word[8]});
        end
    end

    task automatic clear_inputs();
        pop_we = 0; pop_half = 0; iret_we = 0; task_we = 0; alu_we = 0; step = 0;
    endtask

    // driver: inputs already set; predict, push, advance one cycle
    task automatic apply(input string tag);
        exp_t e;
        e.word  = model(model_q);
        e.tag   = tag;
        model_q = e.word;
        sbq.push_back(e);
        @(posedge clk);
        @(negedge clk);
        clear_inputs();
    endtask

    initial begin
        #200000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        exp_t r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_q = 32'h0000_0002;
        r.word = 32'h0000_0002; r.tag = "R1 reset value";
        sbq.push_back(r);
        @(posedge clk); @(negedge clk);

        // pop all ones, id disabled: VM and ID kept, reserved fixed
        cpl = 0; id_en = 0; pop_we = 1; pop_d = 32'hFFFF_FFFF;
        apply("R6 R3 R2 pop ones no id");
        check("R2 literal", flags, 32'h0005_7FD7);

        id_en = 1; pop_we = 1; pop_d = 32'hFFFF_FFFF;
        apply("R3 id enabled pop");
        check("R3 id set", {31'h0, id_b}, 32'h1);

        // cpl 3 with iopl 3: IF writable, IOPL kept
        cpl = 3; id_en = 0; pop_we = 1; pop_d = 32'h0;
        apply("R5 R4 pop at cpl3");
        check("R5 iopl kept", {30'h0, iopl_b}, 32'h3);

        cpl = 0; pop_we = 1; pop_d = 32'h0000_0000;
        apply("R5 pop at cpl0 clears iopl");

        cpl = 2; pop_we = 1; pop_d = 32'h0000_0200;
        apply("R4 IF gated at cpl2");
        check("R4 if stays 0", {31'h0, if_b}, 32'h0);

        cpl = 0; pop_we = 1; pop_half = 1; pop_d = 32'hFFFF_0F00;
        apply("R9 half pop");

        cpl = 1; iret_we = 1; iret_d = 32'h0002_0000;
        apply("R7 iret cpl1 vm kept");

        cpl = 0; iret_we = 1; iret_d = 32'h0002_3200;
        apply("R7 iret cpl0 vm set");
        check("R7 vm", {31'h0, vm_b}, 32'h1);

        cpl = 3; task_we = 1; task_d = 32'h0004_4000;
        apply("R8 task switch cpl3");

        cpl = 3; task_we = 1; task_d = 32'h0002_3300;
        apply("R8 task loads vm iopl if");

        cpl = 0; pop_we = 1; pop_d = 32'h0000_08D5; alu_we = 1; aluf = 6'b010101;
        apply("R10 alu overrides pop");

        alu_we = 1; aluf = 6'b101010;
        apply("R10 alu alone");

        pop_we = 1; pop_d = 32'h0000_0100; step = 1;
        apply("R11 step beats pop");
        check("R11 tf", {31'h0, tf_b}, 32'h0);

        pop_we = 1; pop_d = 32'h0000_0100;
        apply("R11 tf set by pop");

        step = 1;
        apply("R11 step alone");

        pop_we = 1; pop_d = 32'h0000_0400; task_we = 1; task_d = 32'h0000_0001;
        apply("R12 task over pop");

        iret_we = 1; iret_d = 32'h0000_0040; pop_we = 1; pop_d = 32'h0000_0080;
        apply("R12 iret over pop");

        cpl = 0; id_en = 0; task_we = 1; task_d = 32'hFFFF_FFFF;
        apply("R3 R2 task ones no id");

        @(posedge clk); @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule